// File: doc/BRIEF.md
# Multicycle FP issue interlock

This block sits in the decode stage of an in-order, single-issue pipeline that has one integer execute path and three floating-point paths: a pipelined adder of four stages, a pipelined multiplier of seven stages and an unpipelined divider that holds one operation for 24 cycles. Each cycle it looks at the decoded instruction waiting in decode (unit class, destination register and file, two source registers and their file) and raises either `issue_o` or `stall_o`. A stall holds that instruction and everything behind it in place until the hazard clears.

Three kinds of hazard are checked in parallel. A divide may not start while the divider still holds an earlier one. A shift register of write-port reservations, one bit per future cycle, refuses any instruction whose register-file write would land in a cycle already booked. A per-register countdown scoreboard, kept separately for the integer and FP files, blocks reads of results that are not yet available (RAW) and writes to a register whose earlier FP producer is still inside its execution stages (WAW), since units of different depth finish out of order.

Top module: `fp_issue_interlock`

## Requirements
- R1: With `id_valid_i` low, both `issue_o` and `stall_o` are low.
- R2: With `id_valid_i` high, exactly one of `issue_o` and `stall_o` is high; an instruction with no hazard issues in the same cycle, so dependent integer operations (unit code 0) issue on consecutive cycles.
- R3: After a divide (unit code 3) issues in cycle t, another divide stalls in cycles t+1 to t+24 and may issue from cycle t+25.
- R4: An instruction issued in cycle t books the write port for cycle t+2 (integer, code 0), t+5 (add, code 1), t+8 (multiply, code 2) or t+25 (divide, code 3); an instruction whose own slot is already booked stalls.
- R5: A source that matches the destination of an instruction issued in cycle t stalls until cycle t+L+1, with L = 0 for integer, 3 for add, 6 for multiply and 24 for divide.
- R6: An instruction whose destination matches that of an FP instruction issued in cycle t stalls while that producer is in its execution stages: through t+4 for add, t+7 for multiply, t+24 for divide; an integer producer never causes this stall.
- R7: Registers match only when both the 5-bit index and the file select agree (`id_dst_fp_i` against `id_src_fp_i` for reads, against `id_dst_fp_i` for writes; 1 = FP file).
- R8: Asserting `rst_ni` low clears every write-port booking, every register countdown and the divider busy count, so nothing issued before reset causes a stall afterwards.
- R9: A stalled instruction books nothing: after it is withdrawn, nothing it named causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode stage holds an instruction |
| id_unit_i | input | 2 | Unit class: 0 integer, 1 FP add, 2 multiply, 3 divide |
| id_dst_i | input | 5 | Destination register index |
| id_dst_fp_i | input | 1 | Destination lies in the FP file |
| id_src1_i | input | 5 | First source register index |
| id_src2_i | input | 5 | Second source register index |
| id_src_fp_i | input | 1 | Both sources lie in the FP file |
| issue_o | output | 1 | Instruction leaves decode this cycle |
| stall_o | output | 1 | Instruction is held in decode this cycle |

## Verification
The properties assume that every valid instruction writes its destination and reads both of its sources, and that the decode fields are stable and defined while `id_valid_i` is high; checks that look back across cycles also assume at least a few cycles have passed since reset. The bench keeps to this by driving only defined codes on the falling edge, holding a stalled instruction unchanged until it issues in the directed cases, and letting the random phase change the decode word freely, which the block must tolerate since a stalled instruction leaves no trace. Register indices in the random phase are drawn from a small set so that hazards of every kind collide often.

// File: rtl/fpil_pkg.sv
`timescale 1ns/1ps
package fpil_pkg;
  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpil_unit_decode.sv
`timescale 1ns/1ps
module fpil_unit_decode #(
  parameter int unsigned ADD_STG = 4,
  parameter int unsigned MUL_STG = 7,
  parameter int unsigned DIV_CYC = 24,
  parameter int unsigned MEM_STG = 1,
  parameter int unsigned OW      = 5,
  parameter int unsigned CW      = 5
) (
  input  logic [1:0]    unit_i,
  output logic [OW-1:0] wp_off_o,
  output logic [CW-1:0] win_o,
  output logic          early_o,
  output logic          is_div_o
);
  import fpil_pkg::*;

  // win: cycles the destination stays in execution stages; early: result
  // forwardable one cycle before the last stage ends (pipelined units)
  always_comb begin
    wp_off_o = OW'(1 + MEM_STG);
    win_o    = '0;
    early_o  = 1'b0;
    is_div_o = 1'b0;
    unique case (unit_e'(unit_i))
      UNIT_INT: begin
        wp_off_o = OW'(1 + MEM_STG);
        win_o    = '0;
      end
      UNIT_ADD: begin
        wp_off_o = OW'(ADD_STG + MEM_STG);
        win_o    = CW'(ADD_STG);
        early_o  = 1'b1;
      end
      UNIT_MUL: begin
        wp_off_o = OW'(MUL_STG + MEM_STG);
        win_o    = CW'(MUL_STG);
        early_o  = 1'b1;
      end
      UNIT_DIV: begin
        wp_off_o = OW'(DIV_CYC + MEM_STG);
        win_o    = CW'(DIV_CYC);
        is_div_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpil_wport_ring.sv
`timescale 1ns/1ps
module fpil_wport_ring #(
  parameter int unsigned LEN = 26,
  parameter int unsigned OW  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] off_i,
  input  logic          book_i,
  output logic          hit_o
);
  // bit k set: write port taken k cycles from now
  logic [LEN-1:0] slot_q, slot_d, sel;

  for (genvar k = 0; k < LEN; k++) begin : g_slot
    assign sel[k] = (off_i == OW'(k));
    if (k < LEN - 1) begin : g_mid
      assign slot_d[k] = slot_q[k+1] | (book_i & (off_i == OW'(k + 1)));
    end else begin : g_top
      assign slot_d[k] = book_i & (off_i == OW'(k + 1));
    end
  end

  assign hit_o = |(slot_q & sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end
endmodule

// File: rtl/fpil_div_gate.sv
`timescale 1ns/1ps
module fpil_div_gate #(
  parameter int unsigned CYC = 24,
  parameter int unsigned CW  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] left_q;

  assign busy_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (start_i) left_q <= CW'(CYC);
    else if (busy_o)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/fpil_scoreboard.sv
`timescale 1ns/1ps
module fpil_scoreboard #(
  parameter int unsigned NENT = 64,
  parameter int unsigned IW   = 6,
  parameter int unsigned CW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [CW-1:0] win_i,
  input  logic          early_i,
  input  logic [IW-1:0] rd_a_idx_i,
  input  logic [IW-1:0] rd_b_idx_i,
  output logic          raw_o,
  output logic          waw_o
);
  logic [NENT-1:0] raw_v, waw_v;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic [CW-1:0] cnt_q;
    logic          early_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q   <= '0;
        early_q <= 1'b0;
      end else if (wr_i && (wr_idx_i == IW'(e))) begin
        cnt_q   <= win_i;
        early_q <= early_i;
      end else if (cnt_q != '0) begin
        cnt_q   <= cnt_q - 1'b1;
      end
    end

    assign raw_v[e] = cnt_q > CW'(early_q);
    assign waw_v[e] = (cnt_q != '0);
  end

  // write check uses the same index as the booking
  assign raw_o = raw_v[rd_a_idx_i] | raw_v[rd_b_idx_i];
  assign waw_o = waw_v[wr_idx_i];
endmodule

// File: rtl/fp_issue_interlock.sv
`timescale 1ns/1ps
module fp_issue_interlock #(
  parameter int unsigned NREG    = 32,
  parameter int unsigned ADD_STG = 4,
  parameter int unsigned MUL_STG = 7,
  parameter int unsigned DIV_CYC = 24,
  parameter int unsigned MEM_STG = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    id_valid_i,
  input  logic [1:0]              id_unit_i,
  input  logic [$clog2(NREG)-1:0] id_dst_i,
  input  logic                    id_dst_fp_i,
  input  logic [$clog2(NREG)-1:0] id_src1_i,
  input  logic [$clog2(NREG)-1:0] id_src2_i,
  input  logic                    id_src_fp_i,
  output logic                    issue_o,
  output logic                    stall_o
);
  import fpil_pkg::*;

  localparam int unsigned RW      = $clog2(NREG);
  localparam int unsigned IW      = RW + 1;
  localparam int unsigned NENT    = 2 * NREG;
  localparam int unsigned MAX_STG = max2(max2(ADD_STG, MUL_STG), max2(DIV_CYC, 1));
  localparam int unsigned WP_LEN  = MAX_STG + MEM_STG + 1;
  localparam int unsigned OW      = $clog2(WP_LEN + 1);
  localparam int unsigned CW      = $clog2(MAX_STG + 1);

  logic [OW-1:0] wp_off;
  logic [CW-1:0] win;
  logic          early, is_div;
  logic          div_busy, wp_hit, raw_hit, waw_hit, hazard;

  fpil_unit_decode #(
    .ADD_STG(ADD_STG), .MUL_STG(MUL_STG), .DIV_CYC(DIV_CYC),
    .MEM_STG(MEM_STG), .OW(OW), .CW(CW)
  ) u_dec (
    .unit_i   (id_unit_i),
    .wp_off_o (wp_off),
    .win_o    (win),
    .early_o  (early),
    .is_div_o (is_div)
  );

  fpil_div_gate #(.CYC(DIV_CYC), .CW(CW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue_o & is_div),
    .busy_o  (div_busy)
  );

  fpil_wport_ring #(.LEN(WP_LEN), .OW(OW)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .off_i  (wp_off),
    .book_i (issue_o),
    .hit_o  (wp_hit)
  );

  fpil_scoreboard #(.NENT(NENT), .IW(IW), .CW(CW)) u_sb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (issue_o),
    .wr_idx_i   ({id_dst_fp_i, id_dst_i}),
    .win_i      (win),
    .early_i    (early),
    .rd_a_idx_i ({id_src_fp_i, id_src1_i}),
    .rd_b_idx_i ({id_src_fp_i, id_src2_i}),
    .raw_o      (raw_hit),
    .waw_o      (waw_hit)
  );

  assign hazard  = (is_div & div_busy) | wp_hit | raw_hit | waw_hit;
  assign issue_o = id_valid_i & ~hazard;
  assign stall_o = id_valid_i & hazard;
endmodule

// File: rtl/fpil_checks.sv
`timescale 1ns/1ps
module fpil_checks #(
  parameter int unsigned NREG    = 32,
  parameter int unsigned ADD_STG = 4,
  parameter int unsigned MUL_STG = 7,
  parameter int unsigned DIV_CYC = 24
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    id_valid_i,
  input logic [1:0]              id_unit_i,
  input logic [$clog2(NREG)-1:0] id_dst_i,
  input logic                    id_dst_fp_i,
  input logic [$clog2(NREG)-1:0] id_src1_i,
  input logic [$clog2(NREG)-1:0] id_src2_i,
  input logic                    id_src_fp_i,
  input logic                    issue_o,
  input logic                    stall_o
);
  logic [2:0] since_rst;
  logic [7:0] div_age;
  logic       warm;

  assign warm = (since_rst == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= '0;
      div_age   <= 8'(DIV_CYC + 1);
    end else begin
      if (!warm) since_rst <= since_rst + 1'b1;
      if (issue_o && id_unit_i == 2'd3) div_age <= 8'd1;
      else if (div_age != 8'hff)        div_age <= div_age + 1'b1;
    end
  end

  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> (!issue_o && !stall_o));

  a_r2_one_of: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_i |-> ($countones({issue_o, stall_o}) == 1));

  a_r3_div_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && id_unit_i == 2'd3) |-> (div_age >= 8'(DIV_CYC + 1)));

  // integer slot two ahead collides with an add issued ADD_STG-1 cycles earlier
  a_r4_port_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && issue_o && id_unit_i == 2'd0)
      |-> !$past(issue_o && id_unit_i == 2'd1, ADD_STG - 1));

  a_r5_raw_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && issue_o && $past(issue_o && id_unit_i == 2'd1))
      |-> (({id_src_fp_i, id_src1_i} != $past({id_dst_fp_i, id_dst_i})) &&
           ({id_src_fp_i, id_src2_i} != $past({id_dst_fp_i, id_dst_i}))));

  a_r6_waw_mul: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && issue_o && $past(issue_o && id_unit_i == 2'd2))
      |-> ({id_dst_fp_i, id_dst_i} != $past({id_dst_fp_i, id_dst_i})));
endmodule

bind fp_issue_interlock fpil_checks #(
  .NREG(NREG), .ADD_STG(ADD_STG), .MUL_STG(MUL_STG), .DIV_CYC(DIV_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .id_valid_i  (id_valid_i),
  .id_unit_i   (id_unit_i),
  .id_dst_i    (id_dst_i),
  .id_dst_fp_i (id_dst_fp_i),
  .id_src1_i   (id_src1_i),
  .id_src2_i   (id_src2_i),
  .id_src_fp_i (id_src_fp_i),
  .issue_o     (issue_o),
  .stall_o     (stall_o)
);

// File: tb/fp_issue_interlock_test.sv
`timescale 1ns/1ps
module fp_issue_interlock_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 1'b0;
  logic [1:0] u = 2'd0;
  logic [4:0] d = '0, s1 = '0, s2 = '0;
  logic       dfp = 1'b0, sfp = 1'b0;
  logic       issue, stall;

  int  errors = 0, checks = 0, cyc = 0;
  bit  done = 0;
  int  q_t[$], q_u[$], q_d[$];

  always #2.5 clk = ~clk;

  fp_issue_interlock uut (
    .clk_i(clk), .rst_ni(rst_n), .id_valid_i(v), .id_unit_i(u),
    .id_dst_i(d), .id_dst_fp_i(dfp), .id_src1_i(s1), .id_src2_i(s2),
    .id_src_fp_i(sfp), .issue_o(issue), .stall_o(stall)
  );

  function automatic int lat(int k);
    return (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 6 : 24;
  endfunction
  function automatic int exec_win(int k);
    return (k == 0) ? 0 : (k == 1) ? 4 : (k == 2) ? 7 : 24;
  endfunction
  function automatic int slot(int k);
    return (k == 0) ? 2 : (k == 1) ? 5 : (k == 2) ? 8 : 25;
  endfunction

  // behavioural reference: list of issued instructions with issue cycle
  function automatic bit model_issue();
    int di, ai, bi, a;
    if (!v) return 1'b0;
    di = int'(dfp) * 32 + int'(d);
    ai = int'(sfp) * 32 + int'(s1);
    bi = int'(sfp) * 32 + int'(s2);
    for (int i = 0; i < q_t.size(); i++) begin
      a = cyc - q_t[i];
      if (u == 2'd3 && q_u[i] == 3 && a <= 24) return 1'b0;
      if (q_t[i] + slot(q_u[i]) == cyc + slot(int'(u))) return 1'b0;
      if ((q_d[i] == ai || q_d[i] == bi) && a <= lat(q_u[i])) return 1'b0;
      if (q_d[i] == di && a <= exec_win(q_u[i])) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit vv, input int uu, input int dd, input bit dffp,
                       input int a, input int b, input bit sffp);
    v = vv; u = 2'(uu); d = 5'(dd); dfp = dffp;
    s1 = 5'(a); s2 = 5'(b); sfp = sffp;
  endtask

  // compare outputs mid-cycle, then advance the model past the edge
  task automatic tick(input string tag, output bit iss);
    bit e;
    #1;
    for (int i = q_t.size() - 1; i >= 0; i--)
      if (cyc - q_t[i] > 30) begin
        q_t.delete(i); q_u.delete(i); q_d.delete(i);
      end
    e = model_issue();
    checks++;
    if (issue !== e || stall !== (v && !e)) begin
      errors++;
      $display("FAIL %s: issue=%0b stall=%0b expected issue=%0b stall=%0b",
               tag, issue, stall, e, v && !e);
    end
    iss = e;
    @(posedge clk);
    if (e) begin
      q_t.push_back(cyc); q_u.push_back(int'(u));
      q_d.push_back(int'(dfp) * 32 + int'(d));
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    bit iss;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(0, 0, 0, 0, 0, 0, 0);
      tick("idle R1", iss);
    end
  endtask

  task automatic op(input string tag, input int uu, input int dd, input bit dffp,
                    input int a, input int b, input bit sffp, output int stalls);
    bit iss;
    stalls = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      drive(1, uu, dd, dffp, a, b, sffp);
      tick(tag, iss);
      if (iss) break;
      stalls++;
    end
  endtask

  initial begin
    int n;
    bit iss;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    @(negedge clk); drive(0, 3, 1, 1, 1, 1, 1); tick("R1 idle after reset", iss);
    check("R1 no issue when invalid", int'(issue), 0);

    // R2 back-to-back dependent integer ops
    op("R2 int a", 0, 1, 0, 30, 30, 0, n); check("R2 int a stalls", n, 0);
    op("R2 int b", 0, 2, 0, 1, 1, 0, n);   check("R2 int b stalls", n, 0);
    op("R2 int c", 0, 3, 0, 2, 1, 0, n);   check("R2 int c stalls", n, 0);
    idle(30);

    // R3 divider busy
    op("R3 div a", 3, 4, 1, 0, 0, 1, n);
    op("R3 div b", 3, 5, 1, 0, 0, 1, n);   check("R3 second div stalls", n, 24);
    idle(30);

    // R4 write port slot conflict
    op("R4 add", 1, 1, 1, 9, 9, 1, n);
    op("R4 int1", 0, 11, 0, 20, 20, 0, n);
    op("R4 int2", 0, 12, 0, 20, 20, 0, n);
    op("R4 int3", 0, 13, 0, 20, 20, 0, n); check("R4 int3 port stall", n, 1);
    idle(30);

    // R5 RAW latencies
    op("R5 add p", 1, 2, 1, 9, 9, 1, n);
    op("R5 add c", 1, 3, 1, 2, 9, 1, n);   check("R5 add raw", n, 3);
    idle(30);
    op("R5 mul p", 2, 2, 1, 9, 9, 1, n);
    op("R5 mul c", 1, 3, 1, 9, 2, 1, n);   check("R5 mul raw", n, 6);
    idle(30);
    op("R5 div p", 3, 2, 1, 9, 9, 1, n);
    op("R5 div c", 1, 3, 1, 2, 2, 1, n);   check("R5 div raw", n, 24);
    idle(30);

    // R6 WAW
    op("R6 mul", 2, 4, 1, 9, 9, 1, n);
    op("R6 add", 1, 4, 1, 9, 9, 1, n);     check("R6 waw mul->add", n, 7);
    idle(30);
    op("R6 int p", 0, 7, 0, 20, 20, 0, n);
    op("R6 int w", 0, 7, 0, 20, 20, 0, n); check("R6 int no waw", n, 0);
    idle(30);

    // R7 register file separation
    op("R7 add f5", 1, 5, 1, 9, 9, 1, n);
    op("R7 int r5", 0, 6, 0, 5, 5, 0, n);  check("R7 other file read", n, 0);
    op("R7 int w5", 0, 5, 0, 20, 20, 0, n); check("R7 other file write", n, 0);
    idle(30);

    // R9 stalled instruction books nothing
    op("R9 div", 3, 10, 1, 9, 9, 1, n);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); drive(1, 3, 12, 1, 9, 9, 1); tick("R9 held div", iss);
      check("R9 held div stalls", int'(stall), 1);
    end
    op("R9 read f12", 0, 1, 0, 12, 12, 1, n); check("R9 no booking left", n, 0);
    idle(30);

    // R8 reset clears tracking
    op("R8 div", 3, 3, 1, 9, 9, 1, n);
    op("R8 mul", 2, 6, 1, 9, 9, 1, n);
    @(negedge clk); drive(0, 0, 0, 0, 0, 0, 0); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    q_t.delete(); q_u.delete(); q_d.delete();
    cyc += 10;
    op("R8 div after", 3, 6, 1, 3, 3, 1, n); check("R8 div after reset", n, 0);
    idle(30);

    // mixed stream, few registers so hazards collide
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      drive(($urandom % 4) != 0, $urandom % 4, $urandom % 4, $urandom % 2,
            $urandom % 4, $urandom % 4, $urandom % 2);
      tick("mixed", iss);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule